// File: doc/BRIEF.md
# Parallel I/O Group with Programmable Port Directions

This block gives a host 24 general-purpose lines in four slices: two byte-wide ports (A and B) and two independent nibbles of a third port (C upper and C lower). The host reaches the block through a small register window. It has a 2-bit offset, separate read and write strobes and an 8-bit data bus. Offsets 0, 1 and 2 select ports A, B and C. Offset 3 holds a write-only command byte that sets each slice's direction.

Only the plain input/output mode exists. A command byte is accepted only when its top bit is set and its three mode-select bits are clear. An accepted command sets the four direction bits, drives the pad output enables, and clears every output latch so that newly driven lines start at zero. A slice set as output shows its latch on the pads, and a read returns that latch. A slice set as input returns the live pin levels at the read. A system with 48 lines places two instances at offsets 0 to 3 and 4 to 7.

Top module: `pio_group`

## Requirements
- R1: After reset every slice is an input: `pa_oe`, `pb_oe` and both bits of `pc_oe` are 0, all output latches hold 0, and `rdata` is 0.
- R2: An accepted command byte sets directions from bit 4 (port A), bit 1 (port B), bit 3 (port C upper) and bit 0 (port C lower), where 1 means input. Each enable (`pa_oe`, `pb_oe`, `pc_oe[1]` upper, `pc_oe[0]` lower) is the inverse of its bit, from the edge that takes the write.
- R3: A command byte with any of bits 2, 5 or 6 set is ignored: the enables and the latches keep their values.
- R4: A command byte with bit 7 clear is ignored: the enables and the latches keep their values.
- R5: An accepted command byte clears the A, B and C latches to 0.
- R6: A write to offset 0, 1 or 2 stores the byte in the latch of port A, B or C, whatever the direction. The latch appears on `pa_out`, `pb_out` or `pc_out` from the next edge.
- R7: A read of port A or B returns the pin levels sampled at the read edge when the port is an input, and the latch when it is an output.
- R8: A read of port C builds each nibble separately: the upper nibble from pins or latch by its own direction, and the lower nibble likewise.
- R9: A read of offset 3 returns 0xFF.
- R10: Command byte 0x80 makes all four slices outputs.
- R11: `rdata` is registered. It takes the read value at the edge where `rd_en` is sampled high and holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register offset (0 A, 1 B, 2 C, 3 command) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A pad driver enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B pad driver enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 2 | Port C driver enables: bit 1 upper nibble, bit 0 lower nibble |

## Verification
All results are due one edge after their stimulus. A write changes the enables and latches at the edge that samples `wr_en`. A read puts its value in `rdata` at the edge that samples `rd_en`, with the pins taken at that same edge. The bench drives strobes and pins on the falling edge, lets one rising edge pass, and compares at the next falling edge. It holds the pins steady across that window. A following idle cycle checks that `rdata` still holds the read value.

// File: rtl/pio_pkg.sv
// Shared constants and types for the parallel I/O group.
// Assumes an 8-bit command byte whose bit positions are fixed by software.
package pio_pkg;
    localparam int CMD_W = 8;

    localparam logic [1:0] OFS_A   = 2'd0;
    localparam logic [1:0] OFS_B   = 2'd1;
    localparam logic [1:0] OFS_C   = 2'd2;
    localparam logic [1:0] OFS_CMD = 2'd3;

    localparam int BIT_CLO = 0;
    localparam int BIT_B   = 1;
    localparam int BIT_CHI = 3;
    localparam int BIT_A   = 4;
    localparam int BIT_SET = 7;

    // Mode-select bits 2, 5, 6 must be zero for a command to be accepted
    localparam logic [CMD_W-1:0] MODE_MASK = 8'h64;

    // Direction per slice, 1 = input
    typedef struct packed {
        logic a;
        logic b;
        logic chi;
        logic clo;
    } dir_t;

    localparam dir_t DIR_RESET = '{a: 1'b1, b: 1'b1, chi: 1'b1, clo: 1'b1};
endpackage

// File: rtl/pio_cmd.sv
// Command decoder: validates the command byte and holds the slice directions.
// Assumes cmd_wr is a single-cycle strobe. Rejected bytes leave all state alone.
module pio_cmd
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    output dir_t             dir,
    output logic             accept
);
    logic mode_ok;

    // Accept only plain I/O mode with the set flag raised
    always_comb begin
        mode_ok = ((cmd_byte & MODE_MASK) == '0);
        accept  = cmd_wr && cmd_byte[BIT_SET] && mode_ok;
    end

    // Direction register, all inputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_RESET;
        end else if (accept) begin
            dir.a   <= cmd_byte[BIT_A];
            dir.b   <= cmd_byte[BIT_B];
            dir.chi <= cmd_byte[BIT_CHI];
            dir.clo <= cmd_byte[BIT_CLO];
        end
    end
endmodule

// File: rtl/pio_slice.sv
// One port slice: output latch, pad enable and read-source select.
// Assumes wr and clr never coincide. The latch takes writes regardless of direction.
module pio_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins,
    input  logic         is_in,
    output logic [W-1:0] out,
    output logic         oe,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] latch_q;

    // Output latch: cleared on accepted command, loaded on port write
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (clr)   latch_q <= '0;
        else if (wr)    latch_q <= wdata;
    end

    // Pad drive and read source follow the direction bit
    always_comb begin
        out    = latch_q;
        oe     = !is_in;
        rd_val = is_in ? pins : latch_q;
    end
endmodule

// File: rtl/pio_group.sv
// Top of one 24-line parallel I/O group: offset decode, slices and read register.
// Assumes single-cycle read and write strobes that are never high together.
module pio_group
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [1:0]        pc_oe
);
    localparam int NIB_W = DATA_W / 2;

    dir_t              dir;
    logic              accept;
    logic              wr_a, wr_b, wr_c, wr_cmd;
    logic [DATA_W-1:0] a_rd, b_rd, c_rd;
    logic [1:0]        c_is_in;

    // Write strobe decode by offset
    always_comb begin
        wr_a   = wr_en && (addr == OFS_A);
        wr_b   = wr_en && (addr == OFS_B);
        wr_c   = wr_en && (addr == OFS_C);
        wr_cmd = wr_en && (addr == OFS_CMD);
    end

    pio_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_cmd),
        .cmd_byte (wdata[CMD_W-1:0]),
        .dir      (dir),
        .accept   (accept)
    );

    pio_slice #(.W(DATA_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .wr(wr_a), .clr(accept),
        .wdata(wdata), .pins(pa_in), .is_in(dir.a),
        .out(pa_out), .oe(pa_oe), .rd_val(a_rd)
    );

    pio_slice #(.W(DATA_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .wr(wr_b), .clr(accept),
        .wdata(wdata), .pins(pb_in), .is_in(dir.b),
        .out(pb_out), .oe(pb_oe), .rd_val(b_rd)
    );

    // Port C nibble directions: index 1 upper, index 0 lower
    assign c_is_in = {dir.chi, dir.clo};

    for (genvar gi = 0; gi < 2; gi++) begin : g_pc_nib
        pio_slice #(.W(NIB_W)) u_nib (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_c),
            .clr    (accept),
            .wdata  (wdata[gi*NIB_W +: NIB_W]),
            .pins   (pc_in[gi*NIB_W +: NIB_W]),
            .is_in  (c_is_in[gi]),
            .out    (pc_out[gi*NIB_W +: NIB_W]),
            .oe     (pc_oe[gi]),
            .rd_val (c_rd[gi*NIB_W +: NIB_W])
        );
    end

    // Read register: captures the selected source on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (addr)
                OFS_A:   rdata <= a_rd;
                OFS_B:   rdata <= b_rd;
                OFS_C:   rdata <= c_rd;
                default: rdata <= '1;
            endcase
        end
    end
endmodule

// File: rtl/pio_group_chk.sv
// Property checker for pio_group, attached by bind. Observes ports only.
module pio_group_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] pa_out,
    input logic              pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic              pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [1:0]        pc_oe
);
    logic cmd_w;
    assign cmd_w = rst_n && wr_en && (addr == 2'd3);

    // R2
    dir_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[7] && (wdata[6:5] == 2'b00) && !wdata[2]) |=>
        (pa_oe == !$past(wdata[4]) && pb_oe == !$past(wdata[1]) &&
         pc_oe == {!$past(wdata[3]), !$past(wdata[0])}));

    // R3
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && (wdata[6:5] != 2'b00 || wdata[2])) |=>
        ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
         $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    // R4
    no_set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !wdata[7]) |=>
        ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
         $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    // R5
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[7] && (wdata[6:5] == 2'b00) && !wdata[2]) |=>
        (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R9
    cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> (rdata == '1));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

bind pio_group pio_group_chk #(.DATA_W(DATA_W)) u_pio_group_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/test_pio_group.sv
module test_pio_group;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe;
    logic [1:0] pc_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state, direction 1 = input
    bit       m_a = 1, m_b = 1, m_chi = 1, m_clo = 1;
    bit [7:0] l_a = 0, l_b = 0, l_c = 0;

    always #2 clk = ~clk;

    pio_group i_pio_group (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit valid_cmd(logic [7:0] d);
        return d[7] && ((d & 8'h64) == 0);
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return m_a ? pa_in : l_a;
            2'd1: return m_b ? pb_in : l_b;
            2'd2: return {m_chi ? pc_in[7:4] : l_c[7:4], m_clo ? pc_in[3:0] : l_c[3:0]};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check_pads(string req);
        chk(req, {4'b0, pa_oe, pb_oe, pc_oe}, {4'b0, !m_a, !m_b, !m_chi, !m_clo});
        chk(req, pa_out, l_a);
        chk(req, pb_out, l_b);
        chk(req, pc_out, l_c);
    endtask

    task automatic do_write(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
        if (a == 2'd3) begin
            if (valid_cmd(d)) begin
                m_a = d[4]; m_b = d[1]; m_chi = d[3]; m_clo = d[0];
                l_a = 0; l_b = 0; l_c = 0;
            end
        end else if (a == 2'd0) l_a = d;
        else if (a == 2'd1) l_b = d;
        else l_c = d;
    endtask

    task automatic do_read(string req, logic [1:0] a);
        logic [7:0] e;
        addr = a; rd_en = 1'b1;
        pa_in = $urandom; pb_in = $urandom; pc_in = $urandom;
        e = exp_read(a);
        cyc();
        rd_en = 1'b0;
        chk(req, rdata, e);
        pa_in = ~pa_in; pb_in = ~pb_in; pc_in = ~pc_in;
        cyc();
        chk("R11 hold", rdata, e);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) cyc();
        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        check_pads("R1");
        rst_n = 1'b1;
        cyc();
        // R7 inputs after reset return live pins
        do_read("R7 A input", 2'd0);
        do_read("R7 B input", 2'd1);
        // R10 0x80 -> all outputs
        do_write(2'd3, 8'h80);
        chk("R10 oe", {4'b0, pa_oe, pb_oe, pc_oe}, 8'h0F);
        // R6 latch writes
        do_write(2'd0, 8'hA5); do_write(2'd1, 8'h3C); do_write(2'd2, 8'h96);
        check_pads("R6");
        do_read("R7 A output", 2'd0);
        // R3 mode bits rejected
        do_write(2'd3, 8'h84); check_pads("R3 bit2");
        do_write(2'd3, 8'hBF); check_pads("R3 bit5");
        do_write(2'd3, 8'hC0); check_pads("R3 bit6");
        // R4 no set flag rejected
        do_write(2'd3, 8'h1B); check_pads("R4");
        // R5/R2 valid command clears latches, sets directions
        do_write(2'd3, 8'h89); check_pads("R5 R2");
        do_write(2'd2, 8'h5A);
        // R8 mixed nibble read: upper input, lower input here; then swap
        do_read("R8 C both in", 2'd2);
        do_write(2'd3, 8'h88); do_write(2'd2, 8'hE7);
        do_read("R8 C hi in lo out", 2'd2);
        do_write(2'd3, 8'h81); do_write(2'd2, 8'h7E);
        do_read("R8 C hi out lo in", 2'd2);
        // R9 command offset read
        do_read("R9", 2'd3);
        // random phase
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 3);
            if (op == 0) begin
                logic [7:0] d = $urandom;
                if ($urandom_range(0, 1) == 1) d = (d & 8'h1B) | 8'h80;
                do_write(2'd3, d);
                check_pads(valid_cmd(d) ? "R2 R5 rand" : "R3 R4 rand");
            end else if (op == 1) begin
                do_write(2'($urandom_range(0, 2)), 8'($urandom));
                check_pads("R6 rand");
            end else begin
                do_read("R7 R8 R9 rand", 2'($urandom_range(0, 3)));
            end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule